// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a four-bank DDR SDRAM refreshed on behalf of its memory controller. A free-running interval counter adds one owed refresh every `TREFI` controller cycles. The block keeps a backlog of owed refreshes that never wraps and stops growing at `MAX_OWED`. While anything is owed, the block asks the command arbiter for a refresh slot at low priority. When the backlog is full, it raises an urgent flag that tells the arbiter to close every open row. The arbiter signals that it has put an auto-refresh command (chip select, row strobe and column strobe low, write enable high, clock enable held high) on the bus by pulsing `grant`. The scheduler then holds the command path off for the refresh row cycle time `TRFC`.

The block also handles self refresh. When the system asks for it and all banks are precharged, the block drops the clock-enable level. It keeps the level low until the request is withdrawn. Entering self refresh clears the backlog, because the device refreshes itself while in that state. On exit, the interval count starts again from zero. Two independent lockout timers then run, one against bank activation for `TXSA` cycles and one against reads for `TXSR` cycles.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `ref_req`, `ref_urgent`, `busy`, `act_lock` and `rd_lock` are 0 and `cke` is 1.
- R2: The backlog grows by one at every `TREFI`-th clock edge counted from reset release or from self-refresh exit. In normal operation (not busy, `cke` high), `ref_req` is 1 exactly when the backlog is non-zero.
- R3: The backlog never exceeds `MAX_OWED`, and an interval that ends while it is full is dropped. `ref_urgent` is 1 exactly when the backlog equals `MAX_OWED` in normal operation.
- R4: A `grant` is accepted only in normal operation, with `ref_req` high and `banks_idle` high. An accepted grant lowers the backlog by one. Any other grant has no effect on the outputs.
- R5: After an accepted grant, `busy` is 1 and `ref_req` and `ref_urgent` are 0 for exactly `TRFC` cycles. Grants and self-refresh requests in that window are ignored.
- R6: In normal operation with `sr_req` and `banks_idle` high and no accepted grant, `cke` goes low at the next edge. While `cke` is low, `busy` is 1 and `ref_req` and `ref_urgent` are 0. On entry the backlog is cleared.
- R7: While `cke` is low, a low `sr_req` raises `cke` at the next edge and returns the block to normal operation.
- R8: After self-refresh exit, `act_lock` stays 1 for exactly `TXSA` cycles and `rd_lock` for exactly `TXSR` cycles. The two timers run independently.
- R9: An interval end and an accepted grant at the same edge leave the backlog unchanged, including when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All four banks are precharged |
| grant | input | 1 | Arbiter issued the refresh command this cycle |
| sr_req | input | 1 | Request to enter (high) or leave (low) self refresh |
| ref_req | output | 1 | A refresh is owed (low priority) |
| ref_urgent | output | 1 | Backlog full; banks must be closed for refresh |
| cke | output | 1 | Clock-enable level for the device |
| busy | output | 1 | Refresh cycle time or self refresh in progress |
| act_lock | output | 1 | Bank activation blocked after self-refresh exit |
| rd_lock | output | 1 | Reads blocked after self-refresh exit |

## Verification
The bench builds the block with `TREFI`=6, `TRFC`=3, `TXSA`=4 and `TXSR`=9, and keeps the backlog limit at 8. With these values, the backlog fills in about fifty cycles. Intervals that end while the backlog is full, and interval ends that coincide with a grant at the full level, therefore occur many times within a short run. The exit lockouts have different lengths, so a timer that has been swapped or shared shows up. A cycle-level model derived from the requirements is compared with every output on every cycle, across sweeps of grant, idle and self-refresh patterns.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_RFC  = 2'd1,
        ST_SELF = 2'd2
    } rs_state_e;

    function automatic int bits_for(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval
    import refsched_pkg::*;
#(
    parameter int TREFI = 1040
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = bits_for(TREFI - 1);
    localparam logic [CW-1:0] LAST = CW'(TREFI - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && TREFI > 1) |=> !tick);

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt
    import refsched_pkg::*;
#(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic pending,
    output logic full
);
    localparam int OW = bits_for(MAX_OWED);
    localparam logic [OW-1:0] TOP = OW'(MAX_OWED);

    logic [OW-1:0] owed;
    logic          add;

    assign pending = (owed != '0);
    assign full    = (owed == TOP);
    // an interval ending at the limit is dropped unless a refresh leaves at once
    assign add     = inc && (!full || dec);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            owed <= '0;
        end else begin
            case ({add, dec})
                2'b10:   owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        owed <= TOP);
    assert_dec_pending_R4: assert property (@(posedge clk) disable iff (rst)
        dec |-> pending);
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (full && inc && !clr) |=> full);

endmodule

// File: rtl/refsched_downtimer.sv
module refsched_downtimer
    import refsched_pkg::*;
#(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active,
    output logic last
);
    generate
        if (LEN == 0) begin : g_none
            assign active = 1'b0;
            assign last   = 1'b0;
        end else begin : g_count
            localparam int TW = bits_for(LEN);
            logic [TW-1:0] cnt;

            assign active = (cnt != '0);
            assign last   = (cnt == TW'(1));

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (load) begin
                    cnt <= TW'(LEN);
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assert_timer_start_R8: assert property (@(posedge clk) disable iff (rst)
                load |=> active);
        end
    endgenerate

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int TREFI    = 1040,
    parameter int TRFC     = 10,
    parameter int MAX_OWED = 8,
    parameter int TXSA     = 10,
    parameter int TXSR     = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic banks_idle,
    input  logic grant,
    input  logic sr_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic cke,
    output logic busy,
    output logic act_lock,
    output logic rd_lock
);
    localparam int TRFC_EFF = (TRFC < 1) ? 1 : TRFC;

    rs_state_e state, state_nx;
    logic tick, pending, full;
    logic accept, sr_enter, sr_exit;
    logic rfc_active, rfc_last;
    logic act_last_unused, rd_last_unused;

    assign accept   = (state == ST_RUN) && grant && pending && banks_idle;
    assign sr_enter = (state == ST_RUN) && !accept && sr_req && banks_idle;
    assign sr_exit  = (state == ST_SELF) && !sr_req;

    refsched_interval #(.TREFI(TREFI)) u_interval (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_SELF),
        .tick (tick)
    );

    refsched_debt #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .dec     (accept),
        .clr     (sr_enter),
        .pending (pending),
        .full    (full)
    );

    refsched_downtimer #(.LEN(TRFC_EFF)) u_rfc (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .active (rfc_active),
        .last   (rfc_last)
    );

    refsched_downtimer #(.LEN(TXSA)) u_act (
        .clk    (clk),
        .rst    (rst),
        .load   (sr_exit),
        .active (act_lock),
        .last   (act_last_unused)
    );

    refsched_downtimer #(.LEN(TXSR)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .load   (sr_exit),
        .active (rd_lock),
        .last   (rd_last_unused)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (accept)        state_nx = ST_RFC;
                else if (sr_enter) state_nx = ST_SELF;
            end
            ST_RFC:  if (rfc_last) state_nx = ST_RUN;
            ST_SELF: if (sr_exit)  state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    assign ref_req    = (state == ST_RUN) && pending;
    assign ref_urgent = (state == ST_RUN) && full;
    assign cke        = (state != ST_SELF);
    assign busy       = (state != ST_RUN);

    assert_urgent_implies_req_R3: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);
    assert_refresh_holds_busy_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !ref_req && cke));
    assert_rfc_timer_in_rfc_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RFC) |-> rfc_active);
    assert_entry_needs_idle_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> $past(banks_idle && sr_req));
    assert_self_is_busy_R6: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (busy && !ref_req && !ref_urgent));
    assert_exit_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(!sr_req));
    assert_exit_locks_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> ((act_lock || TXSA == 0) && (rd_lock || TXSR == 0)));

endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int TREFI = 6;
    localparam int TRFC  = 3;
    localparam int MAXO  = 8;
    localparam int TXSA  = 4;
    localparam int TXSR  = 9;
    localparam int RUN = 0, RFC = 1, SLF = 2;

    logic clk = 1'b0;
    logic rst, banks_idle, grant, sr_req;
    logic ref_req, ref_urgent, cke, busy, act_lock, rd_lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // requirement-level model state
    int m_st, m_owed, m_cnt, m_rfc, m_act, m_rd;

    always #5 clk = ~clk;

    refresh_sched #(
        .TREFI(TREFI), .TRFC(TRFC), .MAX_OWED(MAXO), .TXSA(TXSA), .TXSR(TXSR)
    ) u0 (
        .clk(clk), .rst(rst), .banks_idle(banks_idle), .grant(grant),
        .sr_req(sr_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .cke(cke), .busy(busy), .act_lock(act_lock), .rd_lock(rd_lock)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_st = RUN; m_owed = 0; m_cnt = 0; m_rfc = 0; m_act = 0; m_rd = 0;
        end else begin
            bit tk, acc, ent, ext;
            tk  = (m_st != SLF) && (m_cnt == TREFI - 1);
            acc = (m_st == RUN) && grant && (m_owed != 0) && banks_idle;
            ent = (m_st == RUN) && !acc && sr_req && banks_idle;
            ext = (m_st == SLF) && !sr_req;
            // R9: interval end and grant together cancel out even at the limit
            if (ent) m_owed = 0;
            else m_owed = m_owed + ((tk && (m_owed < MAXO || acc)) ? 1 : 0) - (acc ? 1 : 0);
            m_cnt = (m_st == SLF || m_cnt == TREFI - 1) ? 0 : m_cnt + 1;
            if (m_act > 0) m_act = m_act - 1;
            if (m_rd > 0)  m_rd  = m_rd - 1;
            case (m_st)
                RUN: if (acc) begin m_st = RFC; m_rfc = TRFC; end
                     else if (ent) m_st = SLF;
                RFC: begin m_rfc = m_rfc - 1; if (m_rfc == 0) m_st = RUN; end
                default: if (ext) begin m_st = RUN; m_act = TXSA; m_rd = TXSR; end
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 ref_req",          ref_req,    (m_st == RUN && m_owed != 0) ? 1 : 0);
        chk("R3 R9 ref_urgent",    ref_urgent, (m_st == RUN && m_owed == MAXO) ? 1 : 0);
        chk("R6 R7 cke",           cke,        (m_st != SLF) ? 1 : 0);
        chk("R4 R5 busy",          busy,       (m_st != RUN) ? 1 : 0);
        chk("R8 act_lock",         act_lock,   (m_act != 0) ? 1 : 0);
        chk("R8 rd_lock",          rd_lock,    (m_rd != 0) ? 1 : 0);
    endtask

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic step(input bit idle, input bit g, input bit sr);
        @(negedge clk);
        compare_all();
        banks_idle = idle; grant = g; sr_req = sr;
    endtask

    initial begin
        rst = 1'b1; banks_idle = 1'b0; grant = 1'b0; sr_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1: values under reset
        chk("R1 ref_req", ref_req, 0);
        chk("R1 ref_urgent", ref_urgent, 0);
        chk("R1 cke", cke, 1);
        chk("R1 busy", busy, 0);
        chk("R1 locks", act_lock | rd_lock, 0);
        rst = 1'b0;
        // R2 R3: backlog fills and saturates with no grants
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0);
        chk("R3 urgent at limit", ref_urgent, 1);
        // R4: grants while banks are open are ignored
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0);
        chk("R4 backlog kept", ref_urgent, 1);
        // R5 R9: drain with continuous grants
        for (int i = 0; i < 80; i++) step(1'b1, 1'b1, 1'b0);
        // sweep of grant and idle patterns
        for (int p = 1; p < 8; p++) begin
            for (int i = 0; i < 90; i++)
                step(((i + p) % 3) != 0, ((i * p) % 5) < 2, 1'b0);
        end
        // R6: self-refresh request with banks open does nothing
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b1);
        chk("R6 no entry when open", cke, 1);
        // R6 R7 R8: enter, stay, leave, watch lockouts and interval restart
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 15 + r; i++) step(1'b1, r[0], 1'b1);
            for (int i = 0; i < 30 + 3 * r; i++) step(1'b1, (i % 4) == r, (i == 2 && r == 3));
        end
        // self-refresh request arriving during refresh row cycle time
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, i > 0 && i < 20);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule